// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block chooses the two ALU operands for the instruction sitting in the decode/execute register of a five-stage in-order pipeline. The register file has no write-through path, so a value written back in a given cycle cannot reach a read made in decode during that same cycle. A trailing register that holds each writeback result for one extra cycle closes that gap. The unit therefore weighs three producers: the execute/memory register, the memory/writeback register, and the trailing writeback register. For each operand it takes the result of the youngest producer whose destination matches the source register. If no producer matches, it passes through the value that decode read from the register file.

The unit is purely combinational. It takes the four instruction words and the candidate data values, and it drives only the two operands seen by the execute stage. Data for the memory stage is never forwarded. A load that is still in execute/memory cannot serve as a source, because the pipeline's stall logic keeps its dependent instruction back.

Instruction fields: opcode in bits 24:22, first source register in bits 21:19, second source register in bits 18:16, destination register in bits 2:0. Opcodes: 0 add, 1 nor, 2 load, 3 store, 4 branch-if-equal, 5 jump-and-link, 6 halt, 7 no-op.

Top module: `exec_fwd_unit`

## Requirements
- R1: When no valid producer matches the register in bits 21:19 of the decode/execute word, op_a equals de_rega_val.
- R2: An add (0) or nor (1) in execute/memory whose bits 2:0 equal the source register forwards em_alu_result.
- R3: An add, nor or load (2) in memory/writeback whose destination matches forwards mw_write_data.
- R4: An add, nor or load in the trailing writeback register whose destination matches forwards tail_write_data.
- R5: When several producers match, execute/memory beats memory/writeback, and memory/writeback beats the trailing register.
- R6: A load (2) in execute/memory never forwards, even when its bits 18:16 match. The operand then comes from the next older match or from decode.
- R7: Opcodes 3, 4, 5, 6 and 7 never act as producers, whatever their register fields hold.
- R8: The destination is bits 2:0 for add and nor, and bits 18:16 for load. The other field of those words is ignored.
- R9: op_b is the forwarded value of the register in bits 18:16 for every opcode except load (2) and store (3), for which op_b equals de_offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| de_instr | input | 32 | Instruction word in decode/execute |
| em_instr | input | 32 | Instruction word in execute/memory |
| mw_instr | input | 32 | Instruction word in memory/writeback |
| tail_instr | input | 32 | Instruction word in trailing writeback register |
| de_rega_val | input | DATA_W | First source value read in decode |
| de_regb_val | input | DATA_W | Second source value read in decode |
| de_offset | input | DATA_W | Sign-extended offset from decode |
| em_alu_result | input | DATA_W | ALU result held in execute/memory |
| mw_write_data | input | DATA_W | Writeback data held in memory/writeback |
| tail_write_data | input | DATA_W | Data held in trailing writeback register |
| op_a | output | DATA_W | First ALU operand |
| op_b | output | DATA_W | Second ALU operand or address offset |

## Verification
The bench sweeps every consumer opcode against every opcode combination in the three producer stages. Each producer targets the first source register, the second source register, or an unrelated register, and the consumer's two source registers are sometimes equal. Opcode variety separates real producers from non-producers (R7) and shows the load exclusion in execute/memory (R6). The register choices separate single-source selection from priority among several matches (R5). Producers write their decoy register into the unused destination field, so a wrong field choice (R8) and a reversed priority both show up as wrong operand values.

// File: rtl/exfwd_pkg.sv
// Package: instruction field layout, opcodes and field helpers shared by
// the forwarding unit and its submodules. Assumes a fixed 32-bit word.
package exfwd_pkg;
    localparam int INSTR_W = 32;
    localparam int OP_W    = 3;
    localparam int REG_AW  = 3;
    localparam int OP_LSB  = 22;
    localparam int RA_LSB  = 19;
    localparam int RB_LSB  = 16;
    localparam int RD_LSB  = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_NOR  = 3'd1,
        OP_LW   = 3'd2,
        OP_SW   = 3'd3,
        OP_BEQ  = 3'd4,
        OP_JALR = 3'd5,
        OP_HALT = 3'd6,
        OP_NOOP = 3'd7
    } opcode_e;

    typedef logic [REG_AW-1:0] reg_idx_t;

    function automatic opcode_e op_of(input logic [INSTR_W-1:0] w);
        return opcode_e'(w[OP_LSB +: OP_W]);
    endfunction

    function automatic reg_idx_t ra_of(input logic [INSTR_W-1:0] w);
        return w[RA_LSB +: REG_AW];
    endfunction

    function automatic reg_idx_t rb_of(input logic [INSTR_W-1:0] w);
        return w[RB_LSB +: REG_AW];
    endfunction

    function automatic reg_idx_t rd_of(input logic [INSTR_W-1:0] w);
        return w[RD_LSB +: REG_AW];
    endfunction
endpackage

// File: rtl/exfwd_producer.sv
// Producer decode: says whether one downstream instruction writes a
// register and which one. LOAD_READY clears for the stage where load
// data does not exist yet. Assumes the opcode and register fields have
// already been extracted.
module exfwd_producer
    import exfwd_pkg::*;
#(
    parameter bit LOAD_READY = 1'b1
) (
    input  opcode_e  op,
    input  reg_idx_t rb,
    input  reg_idx_t rd,
    output logic     valid,
    output reg_idx_t dest
);
    // Map the opcode to a write-enable and the field that names the target.
    always_comb begin
        valid = 1'b0;
        dest  = rd;
        unique case (op)
            OP_ADD, OP_NOR: begin
                valid = 1'b1;
                dest  = rd;
            end
            OP_LW: begin
                valid = LOAD_READY;
                dest  = rb;
            end
            default: begin
                valid = 1'b0;
                dest  = rd;
            end
        endcase
    end
endmodule

// File: rtl/exfwd_select.sv
// Priority select for one operand: index 0 is the youngest source. The
// lowest-indexed valid source whose destination equals the wanted
// register wins; with no hit the fallback passes through. pick is a
// one-hot (or zero) record of the winner.
module exfwd_select
    import exfwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NSRC   = 3
) (
    input  reg_idx_t                        want,
    input  logic [NSRC-1:0]                 valid,
    input  logic [NSRC-1:0][REG_AW-1:0]     dest,
    input  logic [NSRC-1:0][DATA_W-1:0]     cand,
    input  logic [DATA_W-1:0]               fallback,
    output logic [DATA_W-1:0]               value,
    output logic [NSRC-1:0]                 pick
);
    logic [NSRC-1:0] hit;

    // Compare every source against the wanted register in parallel.
    for (genvar s = 0; s < NSRC; s++) begin : g_cmp
        assign hit[s] = valid[s] && (dest[s] == want);
    end

    // Take the first hit from the youngest end, else the decode value.
    always_comb begin
        logic found;
        found = 1'b0;
        value = fallback;
        pick  = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (!found && hit[s]) begin
                value   = cand[s];
                pick[s] = 1'b1;
                found   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/exec_fwd_unit.sv
// Execute-stage operand forwarding. Producers, youngest first: the
// execute/memory register (not for loads), memory/writeback, and the
// trailing writeback register that stands in for a register-file bypass.
// Operand B takes the offset for load and store. Purely combinational;
// assumes stall logic elsewhere covers a load followed by a dependent use.
module exec_fwd_unit
    import exfwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [INSTR_W-1:0] de_instr,
    input  logic [INSTR_W-1:0] em_instr,
    input  logic [INSTR_W-1:0] mw_instr,
    input  logic [INSTR_W-1:0] tail_instr,
    input  logic [DATA_W-1:0]  de_rega_val,
    input  logic [DATA_W-1:0]  de_regb_val,
    input  logic [DATA_W-1:0]  de_offset,
    input  logic [DATA_W-1:0]  em_alu_result,
    input  logic [DATA_W-1:0]  mw_write_data,
    input  logic [DATA_W-1:0]  tail_write_data,
    output logic [DATA_W-1:0]  op_a,
    output logic [DATA_W-1:0]  op_b
);
    localparam int NSRC = 3;

    logic [NSRC-1:0][INSTR_W-1:0] st_instr;
    logic [NSRC-1:0][DATA_W-1:0]  st_data;
    logic [NSRC-1:0]              st_valid;
    logic [NSRC-1:0][REG_AW-1:0]  st_dest;
    logic [NSRC-1:0]              pick_a;
    logic [NSRC-1:0]              pick_b;
    logic [DATA_W-1:0]            fwd_b;
    opcode_e                      de_op;
    logic                         uses_offset;
    logic                         unused_bits;

    // Order the producers youngest first: index 0 is execute/memory.
    assign st_instr = {tail_instr, mw_instr, em_instr};
    assign st_data  = {tail_write_data, mw_write_data, em_alu_result};

    // Decode each producer; only the youngest stage refuses loads.
    for (genvar g = 0; g < NSRC; g++) begin : g_prod
        exfwd_producer #(
            .LOAD_READY(g != 0)
        ) u_prod (
            .op    (op_of(st_instr[g])),
            .rb    (rb_of(st_instr[g])),
            .rd    (rd_of(st_instr[g])),
            .valid (st_valid[g]),
            .dest  (st_dest[g])
        );
    end

    // Operand A: first source register of the consumer.
    exfwd_select #(
        .DATA_W (DATA_W),
        .NSRC   (NSRC)
    ) u_sel_a (
        .want     (ra_of(de_instr)),
        .valid    (st_valid),
        .dest     (st_dest),
        .cand     (st_data),
        .fallback (de_rega_val),
        .value    (op_a),
        .pick     (pick_a)
    );

    // Operand B candidate: second source register of the consumer.
    exfwd_select #(
        .DATA_W (DATA_W),
        .NSRC   (NSRC)
    ) u_sel_b (
        .want     (rb_of(de_instr)),
        .valid    (st_valid),
        .dest     (st_dest),
        .cand     (st_data),
        .fallback (de_regb_val),
        .value    (fwd_b),
        .pick     (pick_b)
    );

    // Load and store compute an address, so B becomes the offset.
    assign de_op       = op_of(de_instr);
    assign uses_offset = (de_op == OP_LW) || (de_op == OP_SW);
    assign op_b        = uses_offset ? de_offset : fwd_b;

    // Fields no producer or consumer reads, gathered so they stay visible.
    assign unused_bits = ^{de_instr[INSTR_W-1:OP_LSB+OP_W], de_instr[RB_LSB-1:0],
                           em_instr[INSTR_W-1:OP_LSB+OP_W], em_instr[RA_LSB+REG_AW-1:RA_LSB],
                           em_instr[RB_LSB-1:RD_LSB+REG_AW],
                           mw_instr[INSTR_W-1:OP_LSB+OP_W], mw_instr[RA_LSB+REG_AW-1:RA_LSB],
                           mw_instr[RB_LSB-1:RD_LSB+REG_AW],
                           tail_instr[INSTR_W-1:OP_LSB+OP_W], tail_instr[RA_LSB+REG_AW-1:RA_LSB],
                           tail_instr[RB_LSB-1:RD_LSB+REG_AW]};

    // Cross-checks between the decoders, the selectors and the outputs.
    always_comb begin
        a_r5_single_winner_a: assert ($onehot0(pick_a));
        a_r5_single_winner_b: assert ($onehot0(pick_b));
        a_r1_fallback_a: assert (pick_a != '0 || op_a == de_rega_val);
        a_r2_youngest_a: assert (!pick_a[0] || op_a == em_alu_result);
        a_r6_no_load_young: assert (op_of(em_instr) != OP_LW || (!pick_a[0] && !pick_b[0]));
        a_r7_non_producer: assert (!(op_of(mw_instr) inside {OP_SW, OP_BEQ, OP_JALR, OP_HALT, OP_NOOP})
                                   || (!pick_a[1] && !pick_b[1]));
        a_r9_offset_b: assert (!uses_offset || op_b == de_offset);
    end
endmodule

// File: tb/exec_fwd_unit_bench.sv
// Sweep bench: every consumer opcode against every producer opcode triple,
// each producer aimed at the first source, the second source or a decoy.
module exec_fwd_unit_bench;
    logic        clk = 1'b0;
    logic [31:0] de_instr, em_instr, mw_instr, tail_instr;
    logic [31:0] de_a, de_b, de_off, em_d, mw_d, tail_d;
    logic [31:0] op_a, op_b;
    int          vectors = 0;
    int          miscompares = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    exec_fwd_unit #(.DATA_W(32)) u_exec_fwd_unit (
        .de_instr        (de_instr),
        .em_instr        (em_instr),
        .mw_instr        (mw_instr),
        .tail_instr      (tail_instr),
        .de_rega_val     (de_a),
        .de_regb_val     (de_b),
        .de_offset       (de_off),
        .em_alu_result   (em_d),
        .mw_write_data   (mw_d),
        .tail_write_data (tail_d),
        .op_a            (op_a),
        .op_b            (op_b)
    );

    function automatic logic [31:0] mk(input int op, input int ra, input int rb,
                                       input int rd, input int fill);
        return {7'd0, op[2:0], ra[2:0], rb[2:0], fill[12:0], rd[2:0]};
    endfunction

    // Reference producer rule (R7, R8): add/nor use bits 2:0, load bits 18:16.
    function automatic bit ref_prod(input logic [31:0] w, input bit ld_ok,
                                    output logic [2:0] d);
        d = 3'd0;
        if (w[24:22] == 3'd0 || w[24:22] == 3'd1) begin
            d = w[2:0];
            return 1'b1;
        end
        if (w[24:22] == 3'd2) begin
            d = w[18:16];
            return ld_ok;
        end
        return 1'b0;
    endfunction

    task automatic judge(input string nm, input logic [2:0] r,
                         input logic [31:0] fb, input logic [31:0] act);
        logic [2:0]  d0, d1, d2;
        bit          v0, v1, v2, h0, h1, h2, l0;
        logic [31:0] e;
        string       tag;
        v0 = ref_prod(em_instr, 1'b0, d0);
        v1 = ref_prod(mw_instr, 1'b1, d1);
        v2 = ref_prod(tail_instr, 1'b1, d2);
        h0 = v0 && d0 == r;
        h1 = v1 && d1 == r;
        h2 = v2 && d2 == r;
        l0 = em_instr[24:22] == 3'd2 && em_instr[18:16] == r;
        e = fb;
        if (h2) e = tail_d;
        if (h1) e = mw_d;
        if (h0) e = em_d;
        if (int'(h0) + int'(h1) + int'(h2) > 1) tag = "R5";
        else if (l0)                            tag = "R6";
        else if (h0)                            tag = "R2";
        else if (h1)                            tag = "R3";
        else if (h2)                            tag = "R4";
        else                                    tag = "R1";
        vectors++;
        if (act !== e) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, nm, act, e);
        end
    endtask

    task automatic check_all();
        judge("op_a", de_instr[21:19], de_a, op_a);
        if (de_instr[24:22] == 3'd2 || de_instr[24:22] == 3'd3) begin
            vectors++;
            if (op_b !== de_off) begin
                miscompares++;
                $display("FAIL R9 op_b offset: actual %h expected %h", op_b, de_off);
            end
        end else begin
            judge("op_b", de_instr[18:16], de_b, op_b);
        end
    endtask

    // Producer word builder: the counted field carries r, the ignored one a decoy.
    function automatic logic [31:0] prod_word(input int op, input int r, input int decoy);
        if (op == 0 || op == 1) return mk(op, r, decoy, r, 13'h0a5a);
        if (op == 2)            return mk(op, r, r, decoy, 13'h1234);
        return mk(op, r, r, r, 13'h0fff);
    endfunction

    initial begin : stim
        int n;
        n = 0;
        @(negedge clk);
        // Idle pipeline: all no-ops, operands come straight from decode (R1).
        de_instr = mk(0, 3, 4, 1, 0);
        em_instr = mk(7, 0, 0, 0, 0);
        mw_instr = mk(7, 0, 0, 0, 0);
        tail_instr = mk(7, 0, 0, 0, 0);
        de_a = 32'h1111_1111; de_b = 32'h2222_2222; de_off = 32'h3333_3333;
        em_d = 32'h4444_4444; mw_d = 32'h5555_5555; tail_d = 32'h6666_6666;
        #1 check_all();
        for (int c = 0; c < 8; c++)
        for (int p0 = 0; p0 < 8; p0++)
        for (int p1 = 0; p1 < 8; p1++)
        for (int p2 = 0; p2 < 8; p2++)
        for (int k = 0; k < 27; k++) begin
            int ra, rb, oth, dec, rr[3];
            int kk[3];
            @(negedge clk);
            ra  = (c * 3 + p1 + k) & 7;
            rb  = (ra + 1 + (p2 & 1) * 7) & 7;   // odd p2: both sources equal
            oth = (ra + 2) & 7;
            dec = (ra + 5) & 7;
            kk[0] = k % 3; kk[1] = (k / 3) % 3; kk[2] = k / 9;
            for (int s = 0; s < 3; s++)
                rr[s] = (kk[s] == 0) ? ra : (kk[s] == 1) ? rb : oth;
            de_instr   = mk(c, ra, rb, dec, 13'h1555);
            em_instr   = prod_word(p0, rr[0], dec);
            mw_instr   = prod_word(p1, rr[1], dec);
            tail_instr = prod_word(p2, rr[2], dec);
            de_a   = 32'hA000_0000 ^ n;
            de_b   = 32'hB000_0000 ^ n;
            de_off = 32'hC000_0000 ^ n;
            em_d   = 32'hD000_0000 ^ n;
            mw_d   = 32'hE000_0000 ^ n;
            tail_d = 32'hF000_0000 ^ n;
            n++;
            #1 check_all();
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : watchdog
        repeat (160000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule